// File: doc/BRIEF.md
# SPI EEPROM Word Sequencer

This block moves runs of 16-bit words between a host and a serial EEPROM on a four-wire SPI link (mode 0: SCK idles low, data is valid on the rising edge). The host gives a word offset, a word count and a direction in one request. Write words come in on a valid/ready stream, and read words go out on a second valid/ready stream. When the request ends, the block pulses `done`, with `error` beside it if the request failed.

Before each command the block reads the device status register until the device reports ready. Writes are preceded by a write-enable command. Each word goes over the wire low byte first. A write that reaches the end of an EEPROM page closes the frame and starts a new poll, write-enable and write command at the next address. A read streams all of its words after one command. Parameters set the device size, the address width, the page size, the SCK divider, the poll limit and the CS-high gap.

Top module: `eeprom_word_seq`

## Requirements
- R1: A request is rejected if the offset is at or beyond WORDS, if the count is zero, or if the count exceeds WORDS minus the offset. On rejection, `done` and `error` are both high in the cycle after the request edge, and CS never goes low. A request that ends exactly on the last word is accepted.
- R2: Each command is preceded by a status frame: opcode 0x05 followed by 8 bits shifted in. Bit 0 high means the device is busy, so the frame is repeated with CS driven high in between. After MAX_POLL busy replies, the request ends with `error` and no command is sent.
- R3: The read opcode is 0x03 and the write opcode is 0x02. After the opcode comes the byte address, equal to twice the word offset, sent MSB first in ADDR_BITS bits.
- R4: When ADDR_BITS is 8 and the command's word offset is 128 or more, bit 3 (0x08) is set in the read or write opcode.
- R5: On reads, the first byte received is the low byte of the word. On writes, the low byte is sent first.
- R6: While the block is receiving, MOSI is held low. MISO is sampled at the end of the SCK-high phase. SCK toggles only while CS is low.
- R7: Each write command is preceded by its own write-enable frame, opcode 0x06.
- R8: During a write, if the byte address after a word is a multiple of PAGE_BYTES and words remain, the frame ends. Polling, write-enable and a new write command then resume at that address.
- R9: A read of any legal count uses a single read command, and the device address advances on its own.
- R10: The write stream takes exactly one word per transfer. Once `rd_valid` is high, it and `rd_data` hold steady until `rd_ready` is seen.
- R11: `busy` is high from acceptance until the request ends. `done` is a one-cycle pulse. While the block is idle, CS is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | request strobe, taken while idle |
| req_write | input | 1 | 1 = write words, 0 = read words |
| req_offset | input | 16 | first word offset |
| req_count | input | 16 | number of words |
| busy | output | 1 | request in progress |
| done | output | 1 | one-cycle end-of-request pulse |
| error | output | 1 | failure flag, valid with done |
| wr_data | input | 16 | write word |
| wr_valid | input | 1 | write word present |
| wr_ready | output | 1 | block takes the write word |
| rd_data | output | 16 | read word |
| rd_valid | output | 1 | read word present |
| rd_ready | input | 1 | host takes the read word |
| spi_cs_n | output | 1 | device select, active low |
| spi_sck | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data to device |
| spi_miso | input | 1 | serial data from device |

## Verification
A rejected request produces its result one clock after the edge that samples it, because `done` and `error` are registered on that same edge. The bench applies the request at a falling edge and checks both flags at the next falling edge, then confirms that no CS activity follows. Results of accepted requests depend on the bus and on handshakes, so their arrival time is not fixed. The bench therefore samples outputs only at falling clock edges and takes a word only when valid and ready are seen high together. A behavioural EEPROM model records opcodes, addresses and frame counts, and the bench compares those records with the values the requirements predict once `done` has been seen.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam int IDX_W = 16;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_HIBIT = 8'h08;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_OP, ST_POLL_IN, ST_WREN, ST_CMD_OP, ST_CMD_ADDR,
    ST_RD_WORD, ST_RD_HOLD, ST_WR_WAIT, ST_WR_WORD, ST_GAP, ST_FIN
  } seq_state_t;

  // wire order: first byte on the bus is the low byte of the word
  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [15:0] byte_addr(input logic [IDX_W-1:0] off);
    return {off[14:0], 1'b0};
  endfunction

  function automatic logic [7:0] pick_opcode(input logic [7:0] base,
                                             input logic [IDX_W-1:0] off,
                                             input int abits);
    if (abits == 8 && off >= 16'd128) return base | OPC_HIBIT;
    return base;
  endfunction

  function automatic logic at_page_edge(input logic [IDX_W-1:0] next_off,
                                        input int unsigned page_bytes);
    int unsigned b;
    b = 32'({next_off, 1'b0});
    return (b % page_bytes) == 0;
  endfunction

endpackage

// File: rtl/eeprom_req_check.sv
module eeprom_req_check
  import eeprom_seq_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic [IDX_W-1:0] offset,
  input  logic [IDX_W-1:0] count,
  output logic             ok
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(WORDS);

  logic [IDX_W:0] o_ext, c_ext;
  assign o_ext = {1'b0, offset};
  assign c_ext = {1'b0, count};
  assign ok = (o_ext < LIM) && (c_ext != '0) && (c_ext <= LIM - o_ext);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DIV = 2,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [4:0]    nbits,
  input  logic [DW-1:0] tx,
  output logic [DW-1:0] rx,
  output logic          fin,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic          active;
  logic [CW-1:0] tick;
  logic [4:0]    left;
  logic [DW-1:0] sh_tx;

  assign mosi = active & sh_tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
      left   <= '0;
      sh_tx  <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tick   <= '0;
          left   <= nbits;
          sh_tx  <= tx << (5'(DW) - nbits);
          rx     <= '0;
          sck    <= 1'b0;
        end
      end else if (tick != TOP) begin
        tick <= tick + 1'b1;
      end else begin
        tick <= '0;
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          // sample at the end of the high phase, then drop SCK
          rx    <= {rx[DW-2:0], miso};
          sck   <= 1'b0;
          sh_tx <= sh_tx << 1;
          left  <= left - 1'b1;
          if (left == 5'd1) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_word_seq.sv
module eeprom_word_seq
  import eeprom_seq_pkg::*;
#(
  parameter int WORDS      = 256,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 16,
  parameter int CLK_DIV    = 2,
  parameter int MAX_POLL   = 8,
  parameter int GAP_CYC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_offset,
  input  logic [15:0] req_count,
  output logic        busy,
  output logic        done,
  output logic        error,
  input  logic [15:0] wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int PW = $clog2(MAX_POLL + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLL - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);

  seq_state_t        st, gap_to;
  logic              is_wr, err_pend, launched;
  logic [IDX_W-1:0]  cur_off, left_w;
  logic [PW-1:0]     polls;
  logic [GW-1:0]     gap_cnt;
  logic [15:0]       wr_word;

  logic              req_ok;
  logic              shift_state, eng_start, eng_done;
  logic [4:0]        eng_bits;
  logic [15:0]       eng_tx, eng_rx;

  // named events for the checker
  logic rx_phase, req_reject, poll_retry;

  eeprom_req_check #(.WORDS(WORDS)) u_chk_req (
    .offset(req_offset), .count(req_count), .ok(req_ok)
  );

  spi_shift_engine #(.DIV(CLK_DIV), .DW(16)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .nbits(eng_bits),
    .tx(eng_tx), .rx(eng_rx), .fin(eng_done),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  assign shift_state = (st == ST_POLL_OP) || (st == ST_POLL_IN) || (st == ST_WREN) ||
                       (st == ST_CMD_OP)  || (st == ST_CMD_ADDR) ||
                       (st == ST_RD_WORD) || (st == ST_WR_WORD);
  assign eng_start  = shift_state && !launched;
  assign spi_cs_n   = (st == ST_IDLE) || (st == ST_GAP) || (st == ST_FIN);
  assign busy       = (st != ST_IDLE);
  assign wr_ready   = (st == ST_WR_WAIT);
  assign rx_phase   = (st == ST_POLL_IN) || (st == ST_RD_WORD);
  assign req_reject = (st == ST_IDLE) && req_valid && !req_ok;
  assign poll_retry = (st == ST_POLL_IN) && eng_done && eng_rx[0] && (polls != POLL_LAST);

  always_comb begin
    eng_bits = 5'd8;
    eng_tx   = '0;
    unique case (st)
      ST_POLL_OP:  eng_tx = {8'h00, OPC_RDSR};
      ST_WREN:     eng_tx = {8'h00, OPC_WREN};
      ST_CMD_OP:   eng_tx = {8'h00, pick_opcode(is_wr ? OPC_WRITE : OPC_READ, cur_off, ADDR_BITS)};
      ST_CMD_ADDR: begin
        eng_bits = 5'(ADDR_BITS);
        eng_tx   = byte_addr(cur_off);
      end
      ST_RD_WORD:  eng_bits = 5'd16;
      ST_WR_WORD:  begin
        eng_bits = 5'd16;
        eng_tx   = swap_bytes(wr_word);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      gap_to   <= ST_IDLE;
      is_wr    <= 1'b0;
      err_pend <= 1'b0;
      launched <= 1'b0;
      cur_off  <= '0;
      left_w   <= '0;
      polls    <= '0;
      gap_cnt  <= '0;
      wr_word  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (eng_start) launched <= 1'b1;
      if (eng_done)  launched <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          if (req_ok) begin
            is_wr   <= req_write;
            cur_off <= req_offset;
            left_w  <= req_count;
            polls   <= '0;
            st      <= ST_POLL_OP;
          end else begin
            done  <= 1'b1;
            error <= 1'b1;
          end
        end
        ST_POLL_OP: if (eng_done) st <= ST_POLL_IN;
        ST_POLL_IN: if (eng_done) begin
          st <= ST_GAP;
          if (!eng_rx[0]) begin
            gap_to <= is_wr ? ST_WREN : ST_CMD_OP;
          end else if (polls == POLL_LAST) begin
            gap_to   <= ST_FIN;
            err_pend <= 1'b1;
          end else begin
            polls  <= polls + 1'b1;
            gap_to <= ST_POLL_OP;
          end
        end
        ST_WREN: if (eng_done) begin
          st     <= ST_GAP;
          gap_to <= ST_CMD_OP;
        end
        ST_CMD_OP:   if (eng_done) st <= ST_CMD_ADDR;
        ST_CMD_ADDR: if (eng_done) st <= is_wr ? ST_WR_WAIT : ST_RD_WORD;
        ST_RD_WORD: if (eng_done) begin
          rd_data  <= swap_bytes(eng_rx);
          rd_valid <= 1'b1;
          st       <= ST_RD_HOLD;
        end
        ST_RD_HOLD: if (rd_ready) begin
          rd_valid <= 1'b0;
          cur_off  <= cur_off + 1'b1;
          left_w   <= left_w - 1'b1;
          if (left_w == 16'd1) begin
            st     <= ST_GAP;
            gap_to <= ST_FIN;
          end else begin
            st <= ST_RD_WORD;
          end
        end
        ST_WR_WAIT: if (wr_valid) begin
          wr_word <= wr_data;
          st      <= ST_WR_WORD;
        end
        ST_WR_WORD: if (eng_done) begin
          cur_off <= cur_off + 1'b1;
          left_w  <= left_w - 1'b1;
          if (left_w == 16'd1) begin
            st     <= ST_GAP;
            gap_to <= ST_FIN;
          end else if (at_page_edge(cur_off + 1'b1, PAGE_BYTES)) begin
            polls  <= '0;
            st     <= ST_GAP;
            gap_to <= ST_POLL_OP;
          end else begin
            st <= ST_WR_WAIT;
          end
        end
        ST_GAP: if (gap_cnt == GAP_LAST) begin
          gap_cnt <= '0;
          st      <= gap_to;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        ST_FIN: begin
          done     <= 1'b1;
          error    <= err_pend;
          err_pend <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        spi_mosi,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        rx_phase,
  input logic        req_reject,
  input logic        poll_retry
);
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |=> done && error && spi_cs_n); // R1
  AST_POLL_CS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_retry |=> spi_cs_n); // R2
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase |-> !spi_mosi); // R6
  AST_SCK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R11
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n && !spi_sck); // R11
endmodule

bind eeprom_word_seq eeprom_seq_chk u_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rx_phase(rx_phase), .req_reject(req_reject), .poll_retry(poll_retry)
);

// File: tb/tb_eeprom_word_seq.sv
module tb_eeprom_word_seq;
  localparam int MAXP = 8;
  localparam int PAGE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_offset = 0, req_count = 0;
  logic busy, done, error;
  logic [15:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [15:0] rd_data;
  logic rd_valid, rd_ready = 0;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  eeprom_word_seq #(.WORDS(256), .ADDR_BITS(8), .PAGE_BYTES(PAGE), .CLK_DIV(2),
                    .MAX_POLL(MAXP), .GAP_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_count(req_count), .busy(busy), .done(done),
    .error(error), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- behavioural EEPROM (8-bit address, bit 3 of opcode = A8)
  logic [7:0] mem [0:511];
  logic [7:0] sh = 0, opc = 0, last_wr_opc = 0, last_rd_opc = 0;
  int bitc = 0, addr = 0, last_addr = -1, busy_left = 0;
  int n_cs = 0, n_rdsr = 0, n_wren = 0, n_wrcmd = 0, n_rdcmd = 0;
  bit stuck = 0, wel = 0, wr_no_wel = 0;

  always @(negedge spi_cs_n) begin
    bitc = 0; opc = 0; n_cs++; spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) begin
    if (opc == 8'h05 && busy_left > 0) busy_left--;
    if ((opc & 8'hF7) == 8'h02 && bitc > 16) begin busy_left = 2; wel = 0; end
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      opc = sh;
      if (sh == 8'h05) n_rdsr++;
      if (sh == 8'h06) begin n_wren++; wel = 1; end
      if ((sh & 8'hF7) == 8'h02) begin n_wrcmd++; last_wr_opc = sh; if (!wel) wr_no_wel = 1; end
      if ((sh & 8'hF7) == 8'h03) begin n_rdcmd++; last_rd_opc = sh; end
    end else if (bitc == 16 && ((opc & 8'hF7) == 8'h02 || (opc & 8'hF7) == 8'h03)) begin
      addr = {23'd0, opc[3], sh};
      last_addr = addr;
    end else if (bitc > 16 && (bitc % 8) == 0 && (opc & 8'hF7) == 8'h02) begin
      mem[addr] = sh;
      addr = (addr & ~(PAGE - 1)) | ((addr + 1) & (PAGE - 1));
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    logic [7:0] stat;
    int k;
    if (opc == 8'h05 && bitc >= 8) begin
      stat = {7'd0, (stuck || busy_left > 0)};
      spi_miso = stat[7 - ((bitc - 8) % 8)];
    end else if ((opc & 8'hF7) == 8'h03 && bitc >= 16) begin
      k = bitc - 16;
      spi_miso = mem[(addr + k / 8) % 512][7 - (k % 8)];
    end
  end

  // ---------------- bookkeeping
  int n_cmp = 0, n_bad = 0;
  logic [15:0] wbuf [0:31];
  logic [15:0] rbuf [0:31];
  int got_words = 0, hold_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input bit w, input int off, input int cnt, input bit stall,
                         output bit err);
    int widx, guard, cyc;
    bit was_held;
    logic [15:0] held;
    widx = 0; guard = 0; cyc = 0; err = 0; got_words = 0; hold_bad = 0;
    was_held = 0; held = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_offset = 16'(off); req_count = 16'(cnt);
    @(negedge clk);
    req_valid = 0;
    while (!done && guard < 40000) begin
      if (w) begin
        wr_valid = 1; wr_data = wbuf[widx];
        if (wr_ready) widx++;
      end else begin
        if (was_held && (!rd_valid || rd_data !== held)) hold_bad++;
        rd_ready = !stall || (cyc % 3 == 0);
        if (rd_valid && rd_ready) begin rbuf[got_words] = rd_data; got_words++; end
        was_held = rd_valid && !rd_ready;
        held = rd_data;
      end
      cyc++;
      @(negedge clk);
      guard++;
    end
    err = error;
    wr_valid = 0; rd_ready = 0;
    if (w) check("R10 write words taken", 32'(widx), 32'(cnt));
  endtask

  task automatic t_reset;
    check("R11 reset cs_n", 32'(spi_cs_n), 1);
    check("R11 reset sck", 32'(spi_sck), 0);
    check("R11 reset busy", 32'(busy), 0);
    check("R11 reset done", 32'(done), 0);
  endtask

  task automatic t_reject(input int off, input int cnt);
    int cs0 = n_cs;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_offset = 16'(off); req_count = 16'(cnt);
    @(negedge clk);
    req_valid = 0;
    check("R1 reject done", 32'(done), 1);
    check("R1 reject error", 32'(error), 1);
    repeat (20) @(negedge clk);
    check("R1 reject no bus", 32'(n_cs - cs0), 0);
    check("R11 idle after reject", 32'(busy), 0);
  endtask

  task automatic t_write_basic;
    bit e;
    int r0 = n_rdsr, w0 = n_wren, c0 = n_wrcmd;
    wbuf[0] = 16'hA1B2; wbuf[1] = 16'h1357; wbuf[2] = 16'hC0DE; wbuf[3] = 16'h8001;
    run_req(1, 2, 4, 0, e);
    check("R11 write ok", 32'(e), 0);
    check("R2 one status frame", 32'(n_rdsr - r0), 1);
    check("R7 one wren", 32'(n_wren - w0), 1);
    check("R7 wren before write", 32'(wr_no_wel), 0);
    check("R3 one write cmd", 32'(n_wrcmd - c0), 1);
    check("R3 write opcode", 32'(last_wr_opc), 32'h02);
    check("R3 byte address", 32'(last_addr), 4);
    check("R5 low byte first", 32'(mem[4]), 32'hB2);
    check("R5 high byte second", 32'(mem[5]), 32'hA1);
    check("R5 last word high", 32'(mem[11]), 32'h80);
  endtask

  task automatic t_read_basic;
    bit e;
    int r0 = n_rdsr, c0 = n_rdcmd, s0 = n_cs;
    run_req(0, 2, 4, 1, e);
    check("R11 read ok", 32'(e), 0);
    check("R2 busy retries", 32'(n_rdsr - r0), 3);
    check("R2 cs pulsed per attempt", 32'(n_cs - s0), 4);
    check("R9 single read cmd", 32'(n_rdcmd - c0), 1);
    check("R3 read opcode", 32'(last_rd_opc), 32'h03);
    check("R10 words delivered", 32'(got_words), 4);
    check("R10 hold under stall", 32'(hold_bad), 0);
    for (int i = 0; i < 4; i++) check("R5 read word", 32'(rbuf[i]), 32'(wbuf[i]));
  endtask

  task automatic t_page;
    bit e;
    int w0 = n_wren, c0 = n_wrcmd;
    for (int i = 0; i < 5; i++) wbuf[i] = 16'(16'h5A00 + i * 16'h0111);
    run_req(1, 6, 5, 0, e);
    check("R8 write ok", 32'(e), 0);
    check("R8 two write cmds", 32'(n_wrcmd - c0), 2);
    check("R7 two wren", 32'(n_wren - w0), 2);
    check("R8 restart address", 32'(last_addr), 16);
    check("R8 no page wrap", 32'({mem[13], mem[12]}), 32'(wbuf[0]));
    run_req(0, 6, 5, 0, e);
    for (int i = 0; i < 5; i++) check("R8 readback", 32'(rbuf[i]), 32'(wbuf[i]));
  endtask

  task automatic t_a8;
    bit e;
    wbuf[0] = 16'hFACE; wbuf[1] = 16'h0B0E;
    run_req(1, 130, 2, 0, e);
    check("R4 write opcode A8", 32'(last_wr_opc), 32'h0A);
    check("R3 address low bits", 32'(last_addr), 32'h104);
    check("R5 A8 low byte", 32'(mem[260]), 32'hCE);
    run_req(0, 130, 2, 0, e);
    check("R4 read opcode A8", 32'(last_rd_opc), 32'h0B);
    check("R4 readback", 32'(rbuf[1]), 32'h0B0E);
  endtask

  task automatic t_stream;
    bit e;
    int c0 = n_rdcmd;
    for (int i = 0; i < 4; i++) begin
      mem[252 + 2 * i] = 8'(8'h10 + i);
      mem[253 + 2 * i] = 8'(8'hE0 + i);
    end
    run_req(0, 126, 4, 0, e);
    check("R9 one cmd across 128", 32'(n_rdcmd - c0), 1);
    check("R4 no A8 below 128", 32'(last_rd_opc), 32'h03);
    for (int i = 0; i < 4; i++)
      check("R9 streamed word", 32'(rbuf[i]), 32'({8'(8'hE0 + i), 8'(8'h10 + i)}));
  endtask

  task automatic t_last;
    bit e;
    wbuf[0] = 16'h7E55;
    run_req(1, 255, 1, 0, e);
    check("R1 last word accepted", 32'(e), 0);
    run_req(0, 255, 1, 0, e);
    check("R1 last word readback", 32'(rbuf[0]), 32'h7E55);
  endtask

  task automatic t_timeout;
    bit e;
    int r0, c0;
    busy_left = 0; stuck = 1;
    r0 = n_rdsr; c0 = n_rdcmd;
    run_req(0, 0, 1, 0, e);
    check("R2 poll timeout error", 32'(e), 1);
    check("R2 poll attempts", 32'(n_rdsr - r0), MAXP);
    check("R2 no command sent", 32'(n_rdcmd - c0), 0);
    stuck = 0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reject(256, 1);
    t_reject(0, 0);
    t_reject(250, 7);
    t_write_basic();
    t_read_basic();
    t_page();
    t_a8();
    t_stream();
    t_last();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule